// File: doc/BRIEF.md
# Processor Power Mode Controller

This block sequences a processor between five power modes and drives the clock and power controls for each one. The five modes are full speed on the PLL, running straight off the input clock, core halted, deep stop and power-down. Software asks for a mode by writing a three-bit request together with a bypass bit and a PLL-off bit. The controller refuses illegal requests and raises a sticky error flag when it does. It also holds the clocks that come from the PLL gated until a programmable lock interval has passed.

Two behaviours need care. First, a masked wakeup event brings the block out of either of the two stopped-core modes. Where it lands depends on the bypass bit stored with the last accepted request. Second, an interlock keeps the PLL control input switched off only while the block is running from the input clock. The PLL has to be switched back on before the block can move to the full-speed mode or the core-halted mode. The only way out of power-down is reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Reset puts the block in full-on mode with the error flag clear. The mode codes are full-on=0, bypassed-run=1, core-halt=2, deep-stop=3 and power-down=4, and `mode_stat` shows the current code.
- R2: In full-on, `pll_en`=1, `pll_bypass`=0, `core_pwr_en`=1 and `dma_l1_permit`=1. Once the lock interval has passed, `cclk_en`=1 and `sclk_en`=1.
- R3: In bypassed-run, `pll_bypass`=1 and both clocks run with no lock wait. `pll_en` is the inverse of the stored PLL-off bit, and `dma_l1_permit` follows `l1_dma_ok`.
- R4: In core-halt, `cclk_en`=0, `pll_en`=1, `dma_l1_permit`=0 and `pll_bypass` equals the stored bypass bit. The system clock runs, and it waits for lock when it is taken from the PLL.
- R5: In deep-stop, the PLL and both clocks are off, `dma_l1_permit`=0 and `core_pwr_en`=1. Power-down is the same except that `core_pwr_en`=0.
- R6: In core-halt or deep-stop, a cycle in which some bit of `wake_evt` is high and the same bit of `wake_mask` is set moves the block on the next edge. It goes to full-on if the stored bypass bit is 0 and to bypassed-run if it is 1. Masked events, and events in any other mode, change nothing.
- R7: In power-down, wakeup events are ignored and every write is refused. Only reset leaves the mode.
- R8: A write with the PLL-off bit set is accepted only when the requested mode is bypassed-run.
- R9: While the stored PLL-off bit is set, a request for full-on or core-halt is refused. A request for bypassed-run with PLL-off=0 must come first.
- R10: A refused write, which includes request codes 5 to 7, leaves the mode and the stored bypass and PLL-off bits unchanged and sets `req_err`.
- R11: `req_err` holds until a cycle with `err_clr`=1 clears it. If a refusal happens in the same cycle as the clear, the flag stays set.
- R12: Each time the PLL is switched on, and each time the PLL becomes the clock source, `lock_cnt` is loaded. A clock fed by the PLL then stays gated for `lock_cnt` edges after the edge that changed the mode. With `lock_cnt`=0 there is no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Request write strobe |
| cfg_mode | input | 3 | Requested mode code |
| cfg_bypass | input | 1 | Bypass bit stored with the request |
| cfg_plloff | input | 1 | PLL-off bit stored with the request |
| err_clr | input | 1 | Clears the error flag |
| lock_cnt | input | LOCK_W | Lock interval in cycles |
| wake_evt | input | WAKE_W | Wakeup event lines |
| wake_mask | input | WAKE_W | Wakeup enable per line |
| l1_dma_ok | input | 1 | L1 memory set up for DMA in bypassed-run |
| pll_en | output | 1 | PLL enable |
| pll_bypass | output | 1 | Clocks taken from input clock |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| core_pwr_en | output | 1 | Core power enable |
| dma_l1_permit | output | 1 | DMA to L1 allowed |
| mode_stat | output | 3 | Current mode code |
| req_err | output | 1 | Sticky refused-request flag |

## Verification
The bench uses the default widths, WAKE_W=4 and LOCK_W=8, so that masked and unmasked event lines can sit side by side on separate bits. `lock_cnt` is driven to 3 so that the gated window can be seen edge by edge. It is then driven to 0 to cover the case with no gap. These values bring every mode transition, the PLL-off interlock and the error set-versus-clear race within a few hundred cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        M_FULL   = 3'd0,
        M_BYPRUN = 3'd1,
        M_HALT   = 3'd2,
        M_DEEP   = 3'd3,
        M_OFF    = 3'd4
    } pmc_mode_e;

    typedef struct packed {
        pmc_mode_e mode;
        logic      byp;
        logic      plloff;
        logic      err;
    } pmc_state_t;

    // PLL running for a given mode and stored PLL-off bit
    function automatic logic pll_on(pmc_mode_e m, logic plloff);
        case (m)
            M_FULL, M_HALT: pll_on = 1'b1;
            M_BYPRUN:       pll_on = ~plloff;
            default:        pll_on = 1'b0;
        endcase
    endfunction

    // PLL output selected as clock source
    function automatic logic pll_src(pmc_mode_e m, logic byp);
        case (m)
            M_FULL:  pll_src = 1'b1;
            M_HALT:  pll_src = ~byp;
            default: pll_src = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pmc_req_check.sv
module pmc_req_check
    import pmc_pkg::*;
(
    input  pmc_mode_e  cur_mode,
    input  logic [2:0] req_code,
    input  logic       req_plloff,
    input  logic       plloff_q,
    output logic       req_ok
);
    logic code_ok;
    logic want_pll;
    logic off_rule;
    logic lock_rule;

    always_comb begin
        code_ok   = (req_code <= 3'd4);
        want_pll  = (req_code == 3'(M_FULL)) || (req_code == 3'(M_HALT));
        off_rule  = !(req_plloff && (req_code != 3'(M_BYPRUN)));
        lock_rule = !(plloff_q && want_pll);
        req_ok    = code_ok && (cur_mode != M_OFF) && off_rule && lock_rule;
    end

endmodule

// File: rtl/pmc_wake_detect.sv
module pmc_wake_detect #(
    parameter int WAKE_W = 4
) (
    input  logic [WAKE_W-1:0] evt,
    input  logic [WAKE_W-1:0] mask,
    output logic              hit
);
    logic [WAKE_W-1:0] qual;

    for (genvar i = 0; i < WAKE_W; i++) begin : g_line
        assign qual[i] = evt[i] & mask[i];
    end

    assign hit = |qual;

endmodule

// File: rtl/pmc_lock_timer.sv
module pmc_lock_timer #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [LOCK_W-1:0] load_val,
    output logic              locked
);
    localparam logic [LOCK_W-1:0] ONE = {{(LOCK_W-1){1'b0}}, 1'b1};

    logic [LOCK_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign locked = (cnt_q == '0);

    a_r12_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

    a_r12_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pmc_out_decode.sv
module pmc_out_decode
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pmc_mode_e mode,
    input  logic      byp,
    input  logic      plloff,
    input  logic      locked,
    input  logic      l1_dma_ok,
    output logic      pll_en,
    output logic      pll_bypass,
    output logic      cclk_en,
    output logic      sclk_en,
    output logic      core_pwr_en,
    output logic      dma_l1_permit
);
    logic clk_ready;

    always_comb begin
        clk_ready     = !pll_src(mode, byp) || locked;
        pll_en        = pll_on(mode, plloff);
        pll_bypass    = 1'b1;
        cclk_en       = 1'b0;
        sclk_en       = 1'b0;
        core_pwr_en   = 1'b1;
        dma_l1_permit = 1'b0;
        case (mode)
            M_FULL: begin
                pll_bypass    = 1'b0;
                cclk_en       = clk_ready;
                sclk_en       = clk_ready;
                dma_l1_permit = 1'b1;
            end
            M_BYPRUN: begin
                cclk_en       = 1'b1;
                sclk_en       = 1'b1;
                dma_l1_permit = l1_dma_ok;
            end
            M_HALT: begin
                pll_bypass = byp;
                sclk_en    = clk_ready;
            end
            M_DEEP: begin
            end
            default: begin
                core_pwr_en = 1'b0;
            end
        endcase
    end

    a_r2_full_pll: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FULL) |-> (pll_en && !pll_bypass && core_pwr_en && dma_l1_permit));

    a_r4_halt_core: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_HALT) |-> (!cclk_en && pll_en && !dma_l1_permit));

    a_r5_off_power: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OFF) |-> (!core_pwr_en && !pll_en && !sclk_en && !cclk_en));

    a_r12_gate_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !pll_bypass && pll_en) |-> (!cclk_en && !sclk_en));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int WAKE_W = 4,
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_bypass,
    input  logic              cfg_plloff,
    input  logic              err_clr,
    input  logic [LOCK_W-1:0] lock_cnt,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic [WAKE_W-1:0] wake_mask,
    input  logic              l1_dma_ok,
    output logic              pll_en,
    output logic              pll_bypass,
    output logic              cclk_en,
    output logic              sclk_en,
    output logic              core_pwr_en,
    output logic              dma_l1_permit,
    output logic [2:0]        mode_stat,
    output logic              req_err
);
    pmc_state_t st_d, st_q;
    logic       req_ok;
    logic       wake_hit;
    logic       restart;
    logic       locked;
    logic       stopped;

    pmc_req_check u_chk (
        .cur_mode  (st_q.mode),
        .req_code  (cfg_mode),
        .req_plloff(cfg_plloff),
        .plloff_q  (st_q.plloff),
        .req_ok    (req_ok)
    );

    pmc_wake_detect #(.WAKE_W(WAKE_W)) u_wake (
        .evt (wake_evt),
        .mask(wake_mask),
        .hit (wake_hit)
    );

    always_comb begin
        st_d    = st_q;
        stopped = (st_q.mode == M_HALT) || (st_q.mode == M_DEEP);
        if (err_clr) begin
            st_d.err = 1'b0;
        end
        // a write in the same cycle as a wakeup takes precedence
        if (cfg_wr) begin
            if (req_ok) begin
                st_d.mode   = pmc_mode_e'(cfg_mode);
                st_d.byp    = cfg_bypass;
                st_d.plloff = cfg_plloff;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (stopped && wake_hit) begin
            st_d.mode = st_q.byp ? M_BYPRUN : M_FULL;
        end
        restart = (pll_on(st_d.mode, st_d.plloff) && !pll_on(st_q.mode, st_q.plloff))
               || (pll_src(st_d.mode, st_d.byp) && !pll_src(st_q.mode, st_q.byp));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: M_FULL, byp: 1'b0, plloff: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    pmc_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .load_val(lock_cnt),
        .locked  (locked)
    );

    pmc_out_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (st_q.mode),
        .byp          (st_q.byp),
        .plloff       (st_q.plloff),
        .locked       (locked),
        .l1_dma_ok    (l1_dma_ok),
        .pll_en       (pll_en),
        .pll_bypass   (pll_bypass),
        .cclk_en      (cclk_en),
        .sclk_en      (sclk_en),
        .core_pwr_en  (core_pwr_en),
        .dma_l1_permit(dma_l1_permit)
    );

    assign mode_stat = st_q.mode;
    assign req_err   = st_q.err;

    a_r7_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_OFF) |=> (st_q.mode == M_OFF));

    a_r10_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !req_ok) |=> ($stable(st_q.mode) && $stable(st_q.plloff)
                                 && $stable(st_q.byp) && st_q.err));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clr) |=> st_q.err);

    a_r6_wake_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && wake_hit && (st_q.mode == M_HALT || st_q.mode == M_DEEP))
        |=> (st_q.mode == ($past(st_q.byp) ? M_BYPRUN : M_FULL)));

    a_r9_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.plloff |-> (st_q.mode == M_BYPRUN));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic       cfg_bypass = 1'b0;
    logic       cfg_plloff = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] lock_cnt = 8'd3;
    logic [3:0] wake_evt = 4'd0;
    logic [3:0] wake_mask = 4'd0;
    logic       l1_dma_ok = 1'b1;
    logic       pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en, dma_l1_permit, req_err;
    logic [2:0] mode_stat;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_bypass(cfg_bypass), .cfg_plloff(cfg_plloff), .err_clr(err_clr),
        .lock_cnt(lock_cnt), .wake_evt(wake_evt), .wake_mask(wake_mask),
        .l1_dma_ok(l1_dma_ok), .pll_en(pll_en), .pll_bypass(pll_bypass),
        .cclk_en(cclk_en), .sclk_en(sclk_en), .core_pwr_en(core_pwr_en),
        .dma_l1_permit(dma_l1_permit), .mode_stat(mode_stat), .req_err(req_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // pll_en, pll_bypass, cclk, sclk, pwr, dma packed MSB first
    task automatic check_outs(input string req, input logic [5:0] exp);
        check(req, "outputs", int'({pll_en, pll_bypass, cclk_en, sclk_en, core_pwr_en, dma_l1_permit}), int'(exp));
    endtask

    task automatic do_write(input logic [2:0] m, input logic b, input logic o);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = m; cfg_bypass = b; cfg_plloff = o;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_wake(input logic [3:0] ev);
        @(negedge clk);
        wake_evt = ev;
        @(negedge clk);
        wake_evt = 4'd0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "mode after reset", mode_stat, 0);
        check("R1", "err after reset", req_err, 0);
        check_outs("R2", 6'b101111);
    endtask

    task automatic t_byprun();
        do_write(3'd1, 1'b0, 1'b0);
        check("R3", "mode", mode_stat, 1);
        check_outs("R3", 6'b111111);
        l1_dma_ok = 1'b0;
        #1;
        check("R3", "dma follows l1_dma_ok", dma_l1_permit, 0);
        l1_dma_ok = 1'b1;
    endtask

    task automatic t_lock_full();
        do_write(3'd0, 1'b0, 1'b0);
        check("R12", "cclk gated edge0", cclk_en, 0);
        check("R12", "sclk gated edge0", sclk_en, 0);
        @(negedge clk);
        check("R12", "cclk gated edge1", cclk_en, 0);
        @(negedge clk);
        check("R12", "cclk gated edge2", cclk_en, 0);
        @(negedge clk);
        check_outs("R2", 6'b101111);
    endtask

    task automatic t_halt_wake();
        do_write(3'd2, 1'b1, 1'b0);
        check("R4", "mode", mode_stat, 2);
        check_outs("R4", 6'b110110);
        wake_mask = 4'b0001;
        pulse_wake(4'b0010);
        check("R6", "masked event ignored", mode_stat, 2);
        pulse_wake(4'b0001);
        check("R6", "wake with bypass to run", mode_stat, 1);
        pulse_wake(4'b0001);
        check("R6", "event outside stop ignored", mode_stat, 1);
    endtask

    task automatic t_deep_wake();
        do_write(3'd3, 1'b0, 1'b0);
        check("R5", "deep mode", mode_stat, 3);
        check_outs("R5", 6'b010010);
        pulse_wake(4'b0001);
        check("R6", "wake without bypass to full", mode_stat, 0);
        check("R12", "cclk gated after wake", cclk_en, 0);
        repeat (2) @(negedge clk);
        check("R12", "cclk still gated", cclk_en, 0);
        @(negedge clk);
        check("R12", "cclk on after lock", cclk_en, 1);
    endtask

    task automatic t_halt_pll_src();
        do_write(3'd1, 1'b0, 1'b0);
        do_write(3'd2, 1'b0, 1'b0);
        check("R4", "halt on pll sclk gated", sclk_en, 0);
        check("R4", "halt bypass out", pll_bypass, 0);
        repeat (3) @(negedge clk);
        check("R4", "halt sclk after lock", sclk_en, 1);
        pulse_wake(4'b0001);
        check("R6", "halt wake to full", mode_stat, 0);
    endtask

    task automatic t_plloff();
        do_write(3'd3, 1'b0, 1'b1);
        check("R8", "plloff with deep refused", mode_stat, 0);
        check("R8", "err set", req_err, 1);
        clear_err();
        check("R11", "err cleared", req_err, 0);
        do_write(3'd1, 1'b0, 1'b1);
        check("R8", "plloff into run accepted", mode_stat, 1);
        check("R8", "pll off", pll_en, 0);
        do_write(3'd0, 1'b0, 1'b0);
        check("R9", "full refused while pll off", mode_stat, 1);
        check("R9", "err on refusal", req_err, 1);
        clear_err();
        do_write(3'd2, 1'b0, 1'b0);
        check("R9", "halt refused while pll off", mode_stat, 1);
        clear_err();
        do_write(3'd1, 1'b0, 1'b0);
        check("R9", "pll back on", pll_en, 1);
        do_write(3'd0, 1'b0, 1'b0);
        check("R9", "full accepted after re-enable", mode_stat, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_illegal();
        do_write(3'd2, 1'b1, 1'b0);
        do_write(3'd6, 1'b0, 1'b0);
        check("R10", "bad code keeps mode", mode_stat, 2);
        check("R10", "bad code sets err", req_err, 1);
        wake_mask = 4'b0001;
        pulse_wake(4'b0001);
        check("R10", "bypass bit kept after refusal", mode_stat, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_mode = 3'd7; err_clr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; err_clr = 1'b0;
        check("R11", "set wins over clear", req_err, 1);
        @(negedge clk);
        check("R11", "err held", req_err, 1);
        clear_err();
        check("R11", "err clear", req_err, 0);
    endtask

    task automatic t_zero_lock();
        lock_cnt = 8'd0;
        do_write(3'd0, 1'b0, 1'b0);
        check("R12", "zero lock no gap", int'({cclk_en, sclk_en}), 3);
        lock_cnt = 8'd3;
    endtask

    task automatic t_off();
        do_write(3'd4, 1'b0, 1'b0);
        check("R5", "power-down mode", mode_stat, 4);
        check_outs("R5", 6'b010000);
        pulse_wake(4'b0001);
        check("R7", "wake ignored", mode_stat, 4);
        do_write(3'd0, 1'b0, 1'b0);
        check("R7", "write refused", mode_stat, 4);
        check("R7", "err on write", req_err, 1);
        do_reset();
        check("R1", "reset leaves power-down", mode_stat, 0);
        check("R1", "err cleared by reset", req_err, 0);
    endtask

    initial begin
        t_reset();
        t_byprun();
        t_lock_full();
        t_halt_wake();
        t_deep_wake();
        t_halt_pll_src();
        t_plloff();
        t_illegal();
        t_zero_lock();
        t_off();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule